// File: doc/BRIEF.md
# Modulo Up/Up-Down Timer Counter

This block is the shared time base for a set of timer channels. It holds a counter of parameterised width (16 bits by default) that advances once per cycle in which its count enable is high. The prescaler that produces that enable lives elsewhere. A modulo value sets the terminal count. In edge mode the counter counts up and returns to zero after the terminal count. In center-aligned mode it counts up to the terminal count and then back down to zero, like a triangle. A modulo of zero gives free-running operation, in which the all-ones value acts as the terminal count.

An overflow flag is set once per count period. Where it is set depends on the mode. In edge mode it is set on the wrap to zero. In center-aligned mode it is set on the turn from counting up to counting down. The flag is sticky. Software clears it with a two-step handshake: a status read while the flag is set arms the clear, and a later write of 0 to the flag bit clears it. An overflow that lands between the two steps cancels the armed clear.

The current count and direction are exported for the channel units. An interrupt output is also provided, registered as the flag gated by an enable input.

Top module: `tmr_modulo_counter`

## Requirements
- R1: A synchronous reset sets the count to 0, the direction to up (`dir_down`=0), the flag to 0 and `irq` to 0.
- R2: While `cnt_en` is 0, the count and the direction keep their values.
- R3: In edge mode (`center_mode`=0) with a nonzero modulo, an enabled cycle at count == modulo loads 0 and sets the flag on the same edge. Any other enabled cycle adds 1.
- R4: A modulo of 0 selects free-running operation with a terminal count of all ones. In edge mode the step from 0xFFFF to 0x0000 sets the flag.
- R5: In center-aligned mode (`center_mode`=1), an enabled up-counting cycle at a count equal to or above the terminal count sets `dir_down`, subtracts 1 and sets the flag. Enabled down-counting cycles subtract 1.
- R6: In center-aligned mode, an enabled down-counting cycle at count 0 clears `dir_down` and loads 1, and it does not set the flag.
- R7: The flag clears only when a `flag_wr` with `flag_wdata`=0 follows an earlier `stat_rd` issued while the flag was set. A write without that read leaves the flag set.
- R8: An overflow in the cycle of the write, or between the read and the write, keeps the flag set and cancels the armed clear. A write with `flag_wdata`=1 never clears the flag, and any write cancels the arming.
- R9: `irq` is registered. After each edge it equals the new flag ANDed with the `irq_en` sampled at that edge.
- R10: In edge mode, every enabled cycle drives `dir_down` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable (one prescaled tick) |
| center_mode | input | 1 | 0 = edge up-count, 1 = center-aligned up/down |
| modulo | input | CNT_W | Terminal count; 0 = free-running |
| stat_rd | input | 1 | Status read strobe (arms clear when flag set) |
| flag_wr | input | 1 | Status write strobe |
| flag_wdata | input | 1 | Value written to the flag bit |
| irq_en | input | 1 | Interrupt enable |
| count | output | CNT_W | Current count |
| dir_down | output | 1 | 1 while counting down |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets the following corner cases:
- The edge-mode wrap with and without a programmed modulo. A design that wrapped one count late, or missed the 0xFFFF wrap when free-running, would show a wrong count and a missing flag at that step.
- Both center-aligned turns. A design that set the flag at the bottom turn, or repeated the terminal or zero count, would drift from the expected triangle.
- The clear handshake: a write with no prior read, a write of 1, and an overflow that lands between the read and the write. A design with a single-step clear, or one that let a stale arming survive, would drop the flag where it must stay set.
- Mode and modulo changes under random stimulus, including a modulo lowered below the current count.

// File: rtl/tmr_modulo_pkg.sv
package tmr_modulo_pkg;

  // Terminal count: a zero modulo means free-running (all ones).
  function automatic logic [63:0] term_of(input logic [63:0] modv, input int unsigned w);
    logic [63:0] all1;
    all1 = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (modv == 64'd0) ? all1 : modv;
  endfunction

endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_modulo_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             center_mode,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             ovf_evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] cnt_nxt;
  logic             dir_nxt;
  logic [63:0]      term_wide;

  assign term_wide = term_of(64'(modulo), CNT_W);
  assign term      = term_wide[CNT_W-1:0];

  always_comb begin
    cnt_nxt = count;
    dir_nxt = dir_down;
    ovf_evt = 1'b0;
    if (cnt_en) begin
      if (!center_mode) begin
        dir_nxt = 1'b0;
        if (count == term) begin
          cnt_nxt = '0;
          ovf_evt = 1'b1;
        end else begin
          cnt_nxt = count + ONE;
        end
      end else if (!dir_down) begin
        if (count >= term) begin
          cnt_nxt = count - ONE;
          dir_nxt = 1'b1;
          ovf_evt = 1'b1;
        end else begin
          cnt_nxt = count + ONE;
        end
      end else begin
        if (count == '0) begin
          cnt_nxt = ONE;
          dir_nxt = 1'b0;
        end else begin
          cnt_nxt = count - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      dir_down <= 1'b0;
    end else begin
      count    <= cnt_nxt;
      dir_down <= dir_nxt;
    end
  end

endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk,
  input  logic rst,
  input  logic ovf_evt,
  input  logic stat_rd,
  input  logic flag_wr,
  input  logic flag_wdata,
  input  logic irq_en,
  output logic ovf_flag,
  output logic irq
);

  logic armed;
  logic armed_nxt;
  logic flag_nxt;
  logic clr_ok;

  assign clr_ok = flag_wr && !flag_wdata && armed && !ovf_evt;

  always_comb begin
    if (ovf_evt)                  armed_nxt = 1'b0;
    else if (flag_wr)             armed_nxt = 1'b0;
    else if (stat_rd && ovf_flag) armed_nxt = 1'b1;
    else                          armed_nxt = armed;

    if (ovf_evt)     flag_nxt = 1'b1;
    else if (clr_ok) flag_nxt = 1'b0;
    else             flag_nxt = ovf_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      ovf_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      armed    <= armed_nxt;
      ovf_flag <= flag_nxt;
      irq      <= flag_nxt && irq_en;
    end
  end

endmodule

// File: rtl/tmr_modulo_counter.sv
module tmr_modulo_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             center_mode,
  input  logic [CNT_W-1:0] modulo,
  input  logic             stat_rd,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             ovf_flag,
  output logic             irq
);

  logic ovf_evt;

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .cnt_en      (cnt_en),
    .center_mode (center_mode),
    .modulo      (modulo),
    .count       (count),
    .dir_down    (dir_down),
    .ovf_evt     (ovf_evt)
  );

  tmr_ovf_flag u_flag (
    .clk        (clk),
    .rst        (rst),
    .ovf_evt    (ovf_evt),
    .stat_rd    (stat_rd),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .irq_en     (irq_en),
    .ovf_flag   (ovf_flag),
    .irq        (irq)
  );

endmodule

// File: rtl/tmr_modulo_counter_chk.sv
module tmr_modulo_counter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             center_mode,
  input logic [CNT_W-1:0] modulo,
  input logic             flag_wr,
  input logic             flag_wdata,
  input logic             irq_en,
  input logic [CNT_W-1:0] count,
  input logic             dir_down,
  input logic             ovf_flag,
  input logic             irq
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !dir_down && !ovf_flag && !irq));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> ($stable(count) && $stable(dir_down)));

  assert_edge_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !center_mode && modulo != '0 && count == modulo)
      |=> (count == '0 && ovf_flag));

  assert_turn_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(dir_down)) |-> ovf_flag);

  assert_bottom_turn_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && center_mode && dir_down && count == '0)
      |=> (count == CNT_W'(1) && !dir_down));

  assert_clear_needs_write0_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(ovf_flag)) |-> $past(flag_wr && !flag_wdata));

  assert_irq_gating_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (ovf_flag && $past(irq_en))));

  assert_edge_dir_up_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !center_mode) |=> !dir_down);

endmodule

bind tmr_modulo_counter tmr_modulo_counter_chk #(.CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .cnt_en      (cnt_en),
  .center_mode (center_mode),
  .modulo      (modulo),
  .flag_wr     (flag_wr),
  .flag_wdata  (flag_wdata),
  .irq_en      (irq_en),
  .count       (count),
  .dir_down    (dir_down),
  .ovf_flag    (ovf_flag),
  .irq         (irq)
);

// File: tb/test_tmr_modulo_counter.sv
module test_tmr_modulo_counter;

  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0;
  logic         center_mode = 1'b0;
  logic [W-1:0] modulo = '0;
  logic         stat_rd = 1'b0;
  logic         flag_wr = 1'b0;
  logic         flag_wdata = 1'b0;
  logic         irq_en = 1'b0;
  logic [W-1:0] count;
  logic         dir_down;
  logic         ovf_flag;
  logic         irq;

  always #10 clk = ~clk;

  tmr_modulo_counter #(.CNT_W(W)) i_tmr_modulo_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .center_mode(center_mode),
    .modulo(modulo), .stat_rd(stat_rd), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .irq_en(irq_en), .count(count),
    .dir_down(dir_down), .ovf_flag(ovf_flag), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  string tag = "R1";

  // Reference state
  logic [W-1:0] m_cnt = '0;
  logic m_dir = 0, m_flag = 0, m_arm = 0, m_irq = 0, m_ev = 0;

  function automatic logic [W-1:0] term_f(input logic [W-1:0] mv);
    return (mv == '0) ? '1 : mv;
  endfunction

  function automatic logic [W:0] nxt_f(input logic [W-1:0] c, input logic d,
                                       input logic ctr, input logic [W-1:0] mv);
    // returns {dir, count}
    logic [W-1:0] t;
    t = term_f(mv);
    if (!ctr) return {1'b0, (c == t) ? W'(0) : W'(c + 1)};
    if (!d)   return (c >= t) ? {1'b1, W'(c - 1)} : {1'b0, W'(c + 1)};
    return (c == '0) ? {1'b0, W'(1)} : {1'b1, W'(c - 1)};
  endfunction

  function automatic logic ev_f(input logic [W-1:0] c, input logic d,
                                input logic ctr, input logic [W-1:0] mv);
    if (!ctr) return c == term_f(mv);
    return !d && (c >= term_f(mv));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    check(tag, 32'(count), 32'(m_cnt), "count");
    check(tag, 32'(dir_down), 32'(m_dir), "dir_down");
    check(tag, 32'(ovf_flag), 32'(m_flag), "ovf_flag");
    check(tag, 32'(irq), 32'(m_irq), "irq");
  endtask

  // One clock: model consumes the inputs held across the edge, compare at negedge.
  task automatic step();
    logic [W:0] nx;
    logic clr;
    @(posedge clk);
    cyc++;
    if (rst) begin
      m_cnt = '0; m_dir = 0; m_flag = 0; m_arm = 0; m_irq = 0; m_ev = 0;
    end else begin
      m_ev = cnt_en && ev_f(m_cnt, m_dir, center_mode, modulo);
      clr  = flag_wr && !flag_wdata && m_arm && !m_ev;
      if (m_ev)                   m_arm = 0;
      else if (flag_wr)           m_arm = 0;
      else if (stat_rd && m_flag) m_arm = 1;
      if (m_ev)     m_flag = 1;
      else if (clr) m_flag = 0;
      m_irq = m_flag && irq_en;
      if (cnt_en) begin
        nx = nxt_f(m_cnt, m_dir, center_mode, modulo);
        m_cnt = nx[W-1:0];
        m_dir = nx[W];
      end
    end
    @(negedge clk);
    compare_all();
    stat_rd = 0; flag_wr = 0; flag_wdata = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    @(negedge clk);
    tag = "R1"; rst = 1; run(2);
    rst = 0;
    // R2: idle holds
    tag = "R2"; cnt_en = 0; run(3);
    // R3: edge mode modulo 4, wrap sets flag
    tag = "R3"; modulo = 16'd4; cnt_en = 1; run(12);
    // R7: write without read leaves flag; read then write clears
    tag = "R7"; cnt_en = 0;
    flag_wr = 1; step();
    check("R7", 32'(ovf_flag), 32'd1, "flag after unarmed write");
    stat_rd = 1; step();
    flag_wr = 1; step();
    check("R7", 32'(ovf_flag), 32'd0, "flag after read+write0");
    // R8: write 1 does not clear; overflow between read and write keeps flag
    tag = "R8"; cnt_en = 1; run(5);
    cnt_en = 0;
    stat_rd = 1; step();
    flag_wr = 1; flag_wdata = 1; step();
    check("R8", 32'(ovf_flag), 32'd1, "flag after write of 1");
    stat_rd = 1; step();
    cnt_en = 1; run(5);            // passes the wrap: new overflow
    cnt_en = 0; flag_wr = 1; step();
    check("R8", 32'(ovf_flag), 32'd1, "flag after overflow between read and write");
    // R9: irq follows flag when enabled
    tag = "R9"; irq_en = 1; step();
    check("R9", 32'(irq), 32'd1, "irq with enable");
    irq_en = 0; step();
    check("R9", 32'(irq), 32'd0, "irq disabled");
    // R5/R6: center-aligned triangle, modulo 3
    stat_rd = 1; step(); flag_wr = 1; step();
    rst = 1; step(); rst = 0;
    tag = "R5"; center_mode = 1; modulo = 16'd3; cnt_en = 1; run(4);
    check("R5", 32'(dir_down), 32'd1, "dir after top turn");
    check("R5", 32'(ovf_flag), 32'd1, "flag at top turn");
    stat_rd = 1; step(); flag_wr = 1; step();   // count 1 then 0, flag cleared
    tag = "R6"; step();
    check("R6", 32'(count), 32'd1, "count after bottom turn");
    check("R6", 32'(ovf_flag), 32'd0, "no flag at bottom turn");
    // R10: switch to edge while down-counting
    run(3);
    tag = "R10"; center_mode = 0; step();
    check("R10", 32'(dir_down), 32'd0, "dir in edge mode");
    // R4: free-running wrap
    rst = 1; step(); rst = 0;
    tag = "R4"; modulo = '0; center_mode = 0; cnt_en = 1;
    run(65535);
    check("R4", 32'(count), 32'hFFFF, "count before free wrap");
    check("R4", 32'(ovf_flag), 32'd0, "flag before free wrap");
    step();
    check("R4", 32'(count), 32'd0, "count after free wrap");
    check("R4", 32'(ovf_flag), 32'd1, "flag after free wrap");
    // Random mixed phase
    rst = 1; step(); rst = 0;
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 400) == 0) center_mode = ~center_mode;
      if (($urandom % 300) == 0) modulo = W'($urandom % 12);
      cnt_en     = ($urandom % 5) != 0;
      stat_rd    = ($urandom % 6) == 0;
      flag_wr    = ($urandom % 6) == 0;
      flag_wdata = ($urandom % 4) == 0;
      irq_en     = ($urandom % 3) != 0;
      tag = center_mode ? "R5" : "R3";
      step();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule